// File: doc/BRIEF.md
# Audio Converter Power Sequencing Controller

This block is the digital side of the power and reset handling for a stereo audio converter. Software programs a small register file through a write/read port. The registers hold three power enables (reference, ADC, DAC), two active-low section resets and four test bits. The block also holds a left and a right output attenuation target. From these bits the controller decides, in every clock cycle, whether the DAC path and the ADC path may run.

When the DAC path is stopped, both attenuation levels are held at zero. Once the path runs again, each level walks back to its target one step per frame. When the ADC path is stopped, the serial data output is held low. After the path restarts, the output stays blanked for a fixed number of frames before the converter's bit stream is passed through.

No power-down or reset bit clears the register file, and every register can be written while a section is down.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After `rst` the power register (address 0) reads 07h, the reset/test register (address 1) reads 00h, both targets (addresses 2 and 3) read 00h, both attenuation outputs are 00h and `sdto` is 0.
- R2: A write with `wr_en` high takes effect at that clock edge. `rdata` is registered and shows the register selected by `addr` one edge after `addr` is applied. Address 0 holds DAC enable in bit 0, ADC enable in bit 1 and reference enable in bit 2, with bits 7..3 reading 0. Address 1 holds DAC run in bit 0, ADC run in bit 1 and test bits in 7..4, with bits 3..2 reading 0. Address 2 is the left target and address 3 is the right target.
- R3: The DAC path runs only while reference enable, DAC enable and DAC run are all 1. At the first edge after it stops, both attenuation outputs become 00h and any ramp in progress is abandoned. On restart, the ramp starts again from 00h.
- R4: While the DAC path runs, each attenuation output moves one count toward its target at each clock edge where `lrck` is sampled 1 after having been sampled 0 at the previous edge. Between such edges, and once the target is reached, the output holds.
- R5: A new target written during a ramp is followed from the next frame edge, and the level continues from its present value. A write that lands on the same edge as a frame edge lets that step use the old target.
- R6: While the ADC path is stopped (ADC enable or ADC run is 0), `sdto` is 0 from the next edge.
- R7: After the ADC path starts, `sdto` stays 0 until 516 frame edges have been counted. From the edge after the 516th, `sdto` follows `adc_sdata` with one register delay. Every new start begins the count again from zero.
- R8: Reference enable at 0 stops both paths, whatever the other enable and run bits hold.
- R9: Registers keep their contents and accept writes while any path is stopped.
- R10: The test bits are stored and read back, and they have no effect on the attenuation outputs or on `sdto`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lrck | input | 1 | Frame clock, synchronous to clk |
| adc_sdata | input | 1 | Serial bit stream from the ADC |
| att_l | output | 8 | Left output attenuation level |
| att_r | output | 8 | Right output attenuation level |
| sdto | output | 1 | Gated ADC serial data output |

## Verification
A target write and an attenuation step can fall on the same clock edge. The bench provokes this by raising `lrck` in the same cycle that it writes a lower left target while the level is still climbing. It then expects one step up toward the old target, followed by steps down to the new one. The ADC blanking count and the DAC ramp also share every frame edge. The bench runs both across a full 516-frame window and checks the exact frame after which `sdto` is released, as well as the attenuation values reached at that point.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_PWR  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RUN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_TGTL = 2'd2;
  localparam logic [ADDR_W-1:0] A_TGTR = 2'd3;

  localparam int B_DAC  = 0;
  localparam int B_ADC  = 1;
  localparam int B_VREF = 2;

  localparam int N_CH = 2;
endpackage

// File: rtl/pwrseq_regs.sv
module pwrseq_regs
  import pwrseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        pwr_q,
  output logic [1:0]        run_q,
  output logic [DATA_W-1:0] tgt_l,
  output logic [DATA_W-1:0] tgt_r
);
  logic [3:0]        test_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (addr)
      A_PWR:   rd_mux = {5'b0, pwr_q};
      A_RUN:   rd_mux = {test_q, 2'b0, run_q};
      A_TGTL:  rd_mux = tgt_l;
      default: rd_mux = tgt_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_q  <= 3'b111;
      run_q  <= 2'b00;
      test_q <= 4'h0;
      tgt_l  <= '0;
      tgt_r  <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_PWR:   pwr_q <= wdata[2:0];
          A_RUN:   begin
                     run_q  <= wdata[1:0];
                     test_q <= wdata[7:4];
                   end
          A_TGTL:  tgt_l <= wdata;
          default: tgt_r <= wdata;
        endcase
      end
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         step,
  input  logic [W-1:0] target,
  output logic [W-1:0] level
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level <= '0;
    end else if (step) begin
      if (level < target)      level <= level + W'(1);
      else if (level > target) level <= level - W'(1);
    end
  end
endmodule

// File: rtl/pwrseq_adc_gate.sv
module pwrseq_adc_gate #(
  parameter int BLANK = 516,
  parameter int CW    = $clog2(BLANK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          step,
  input  logic          sdin,
  output logic          sdto,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sdto <= 1'b0;
    end else begin
      if (step && cnt != LIMIT) cnt <= cnt + CW'(1);
      sdto <= (cnt == LIMIT) ? sdin : 1'b0;
    end
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int BLANK_FRAMES = 516
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              lrck,
  input  logic              adc_sdata,
  output logic [DATA_W-1:0] att_l,
  output logic [DATA_W-1:0] att_r,
  output logic              sdto
);
  localparam int CNT_W = $clog2(BLANK_FRAMES + 1);

  logic [2:0]        pwr_q;
  logic [1:0]        run_q;
  logic [DATA_W-1:0] tgt_l, tgt_r;
  logic [DATA_W-1:0] tgt   [N_CH];
  logic [DATA_W-1:0] level [N_CH];
  logic              lrck_q, lrck_rise;
  logic              vref_on, dac_on, adc_on;
  logic [CNT_W-1:0]  blank_cnt;

  pwrseq_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_q(pwr_q), .run_q(run_q), .tgt_l(tgt_l), .tgt_r(tgt_r)
  );

  always_ff @(posedge clk) begin
    if (rst) lrck_q <= 1'b0;
    else     lrck_q <= lrck;
  end
  assign lrck_rise = lrck && !lrck_q;

  assign vref_on = pwr_q[B_VREF];
  assign dac_on  = vref_on && pwr_q[B_DAC] && run_q[B_DAC];
  assign adc_on  = vref_on && pwr_q[B_ADC] && run_q[B_ADC];

  assign tgt[0] = tgt_l;
  assign tgt[1] = tgt_r;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwrseq_ramp #(.W(DATA_W)) u_ramp (
      .clk(clk), .rst(rst), .en(dac_on), .step(lrck_rise),
      .target(tgt[c]), .level(level[c])
    );
  end

  assign att_l = level[0];
  assign att_r = level[1];

  pwrseq_adc_gate #(.BLANK(BLANK_FRAMES), .CW(CNT_W)) u_adc (
    .clk(clk), .rst(rst), .en(adc_on), .step(lrck_rise),
    .sdin(adc_sdata), .sdto(sdto), .cnt(blank_cnt)
  );
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk #(
  parameter int BLANK_FRAMES = 516,
  parameter int CNT_W = $clog2(BLANK_FRAMES + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             dac_on,
  input logic             adc_on,
  input logic             vref_on,
  input logic             lrck_rise,
  input logic [CNT_W-1:0] blank_cnt,
  input logic [7:0]       att_l,
  input logic [7:0]       att_r,
  input logic             sdto
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLANK_FRAMES);

  p_dac_off_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(dac_on) |-> (att_l == 8'd0 && att_r == 8'd0));

  p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
    (att_l == $past(att_l)) || (att_l == $past(att_l) + 8'd1) ||
    (att_l == $past(att_l) - 8'd1) || (att_l == 8'd0));

  p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(dac_on) && !$past(lrck_rise)) |-> ($stable(att_l) && $stable(att_r)));

  p_adc_off_low_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(adc_on) |-> !sdto);

  p_blank_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(blank_cnt) != LIMIT) |-> !sdto);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    blank_cnt <= LIMIT);

  p_vref_off_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(vref_on) |-> (att_l == 8'd0 && att_r == 8'd0 && !sdto));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(.BLANK_FRAMES(BLANK_FRAMES)) u_chk (
  .clk(clk), .rst(rst), .dac_on(dac_on), .adc_on(adc_on), .vref_on(vref_on),
  .lrck_rise(lrck_rise), .blank_cnt(blank_cnt), .att_l(att_l), .att_r(att_r),
  .sdto(sdto)
);

// File: tb/pwrseq_ctrl_tb_top.sv
module pwrseq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata, att_l, att_r;
  logic       lrck = 1'b0;
  logic       adc_sdata = 1'b0;
  logic       sdto;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  localparam int K_RD = 0, K_L = 1, K_R = 2, K_SD = 3;

  always #2 clk = ~clk;

  pwrseq_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lrck(lrck), .adc_sdata(adc_sdata),
    .att_l(att_l), .att_r(att_r), .sdto(sdto)
  );

  // monitor: compares every queued item one ns after the next rising edge
  always begin
    @(posedge clk);
    #1;
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_RD:    act = rdata;
        K_L:     act = att_l;
        K_R:     act = att_r;
        default: act = {7'b0, sdto};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); addr = a; push(K_RD, exp, req);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lrck = 1'b1;
      @(negedge clk); lrck = 1'b0;
    end
  endtask

  task automatic att_chk(input logic [7:0] l, input logic [7:0] r, input string req);
    push(K_L, l, req);
    push(K_R, r, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    att_chk(8'h00, 8'h00, "R1");
    push(K_SD, 8'h00, "R1");
    rd_chk(2'd0, 8'h07, "R1");
    rd_chk(2'd1, 8'h00, "R1");
    rd_chk(2'd2, 8'h00, "R1");
    adc_sdata = 1'b1;

    // R2 write and read back
    wr(2'd2, 8'd3);
    wr(2'd3, 8'd5);
    rd_chk(2'd2, 8'd3, "R2");
    rd_chk(2'd3, 8'd5, "R2");

    // R3 DAC held in reset: no ramp
    frames(2);
    att_chk(8'd0, 8'd0, "R3");

    // R4 ramp one step per frame
    wr(2'd1, 8'h01);
    att_chk(8'd0, 8'd0, "R4");
    frames(1);
    att_chk(8'd1, 8'd1, "R4");
    frames(3);
    att_chk(8'd3, 8'd4, "R4");
    frames(1);
    att_chk(8'd3, 8'd5, "R4");
    push(K_SD, 8'h00, "R6");

    // R5 retarget during ramp
    wr(2'd2, 8'd10);
    frames(2);
    push(K_L, 8'd5, "R5");
    @(negedge clk); lrck = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 8'd2;
    @(negedge clk); lrck = 1'b0; wr_en = 1'b0;
    push(K_L, 8'd6, "R5");
    frames(4);
    push(K_L, 8'd2, "R5");
    frames(1);
    push(K_L, 8'd2, "R4");

    // R3 abort and restart from zero, R9 writes while down
    wr(2'd2, 8'd9);
    frames(1);
    push(K_L, 8'd3, "R4");
    wr(2'd0, 8'h06);
    att_chk(8'd0, 8'd0, "R3");
    frames(2);
    att_chk(8'd0, 8'd0, "R3");
    wr(2'd3, 8'd7);
    rd_chk(2'd3, 8'd7, "R9");
    rd_chk(2'd2, 8'd9, "R9");
    rd_chk(2'd1, 8'h01, "R9");
    wr(2'd0, 8'h07);
    att_chk(8'd0, 8'd0, "R3");
    frames(1);
    att_chk(8'd1, 8'd1, "R3");

    // R8 reference off stops both paths
    wr(2'd1, 8'h03);
    frames(8);
    att_chk(8'd9, 8'd7, "R4");
    wr(2'd0, 8'h03);
    att_chk(8'd0, 8'd0, "R8");
    push(K_SD, 8'h00, "R8");
    rd_chk(2'd0, 8'h03, "R9");

    // R7 blanking window after restart
    wr(2'd0, 8'h07);
    frames(515);
    push(K_SD, 8'h00, "R7");
    frames(1);
    push(K_SD, 8'h01, "R7");
    @(negedge clk); adc_sdata = 1'b0;
    push(K_SD, 8'h00, "R7");
    @(negedge clk); adc_sdata = 1'b1;
    push(K_SD, 8'h01, "R7");

    // R10 test bits stored, no effect
    wr(2'd1, 8'hF3);
    push(K_SD, 8'h01, "R10");
    att_chk(8'd9, 8'd7, "R10");
    rd_chk(2'd1, 8'hF3, "R10");

    // R6 ADC reset, R7 restart of count on every new start
    wr(2'd1, 8'hF1);
    push(K_SD, 8'h00, "R6");
    wr(2'd1, 8'hF3);
    frames(300);
    wr(2'd1, 8'hF1);
    wr(2'd1, 8'hF3);
    frames(515);
    push(K_SD, 8'h00, "R7");
    frames(1);
    push(K_SD, 8'h01, "R7");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule